// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block programs a downstream FPGA over a slave-serial configuration link. Software or a DMA engine streams the bitstream as bytes through a valid/ready input. The block is armed by a one-cycle start pulse. It throws away leading header bytes until it sees the synchronisation preamble. It then pulses the FPGA's program line and checks the two edges of the init line. After that it clocks every configuration byte out serially, most significant bit first, and appends a run of all-ones filler bytes. Finally it waits for the done line.

Each wait is bounded by a count of millisecond ticks. These ticks arrive as an input strobe. When a wait runs out, the block stops with one of three distinct error codes. If the done line rises in time, it raises a success flag. The result stays visible until the next start pulse. The stream framing is chosen per run by a mode input sampled at start: plain images sync on a run of all-ones bytes, and packed images sync on an all-ones byte followed by a byte whose upper nibble is 3.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `prog_n`, `cclk` and `din` are all 1, `in_ready` is 0, and after reset `ok` and `err` are 0.
- R2: Each configuration bit takes four clock cycles: (`cclk`=0, `din`=1), (`cclk`=0, `din`=bit), (`cclk`=1, `din`=bit), (`cclk`=1, `din`=1). Bits leave most significant first, and `din` never changes on a cycle where `cclk` rises.
- R3: A `start` pulse while `busy` is low begins a run, raises `busy` and opens `in_ready` to hunt for the preamble. A `start` while `busy` is high has no effect on the run.
- R4: With `cmp_mode`=0 latched at start, every byte before the first run of RUN_LEN (default 4) consecutive 0xFF bytes is dropped. The serial stream begins with that run.
- R5: With `cmp_mode`=1 latched at start, every byte before the first 0xFF byte that is directly followed by a byte with bits [7:4] = 4'h3 is dropped. The serial stream begins with that 0xFF byte.
- R6: Once the preamble is found, `prog_n` goes low with `cclk` and `din` high until `init_n` is seen low. If the INIT_LO_TMO-th `ms_tick` (default 3) arrives first, the run ends with `err`=1.
- R7: After `init_n` goes low, `prog_n` returns high. If `init_n` does not return high before the INIT_HI_TMO-th `ms_tick`, the run ends with `err`=2.
- R8: After the byte flagged by `in_last`, exactly FILL_CNT (default 8) bytes of 0xFF are shifted out.
- R9: After the filler, `cfg_done` high ends the run with `ok`=1 and `err`=0. If the DONE_TMO-th `ms_tick` arrives first, the run ends with `err`=3 and `ok`=0.
- R10: `in_ready` stays low while `prog_n` is low, while `cclk` is low (a bit in flight), and during the init and done waits.
- R11: `ok` and `err` hold their last value while idle and are cleared by the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| cmp_mode | input | 1 | Preamble style, sampled at start: 0 plain, 1 packed |
| ms_tick | input | 1 | One-cycle millisecond strobe for timeouts |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final bitstream byte |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| prog_n | output | 1 | Program request to the FPGA, active low |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| init_n | input | 1 | FPGA init status, active low |
| cfg_done | input | 1 | FPGA configuration complete |
| busy | output | 1 | A run is in progress |
| ok | output | 1 | Last run completed with done seen |
| err | output | 2 | Last run's failure code: 0 none, 1 init stuck high, 2 init stuck low, 3 done missing |

## Verification
`busy`, `ok` and `err` are registered at the same clock edge where the deciding input (`init_n`, `cfg_done` or the last counted `ms_tick`) is sampled. The bench drives inputs at falling edges and reads results at the first falling edge where `busy` is low, which is half a cycle after that edge. The serial stream is rebuilt the way a configuration slave would see it: the bench samples `din` at each falling edge on which `cclk` has just become 1. Because every phase lasts a full clock, each rising edge of `cclk` is seen exactly once. The expected bytes come from a bench search for the preamble with the 0xFF filler appended. The init-stuck-high timeout is checked by counting the ticks the bench offered while `prog_n` was low, and that count must equal the limit when `err` appears.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_PROG,
        ST_INIT_HI,
        ST_STREAM,
        ST_DONE_W
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_NONE          = 2'd0,
        RES_INIT_STUCK_HI = 2'd1,
        RES_INIT_STUCK_LO = 2'd2,
        RES_NO_DONE       = 2'd3
    } res_code_e;

    typedef enum logic [1:0] {
        PH_LOW_IDLE,
        PH_LOW_DATA,
        PH_HIGH_DATA,
        PH_HIGH_IDLE
    } bit_phase_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_sync_tail(input logic [7:0] b);
        return b[7:4] == 4'h3;
    endfunction

endpackage

// File: rtl/fcs_hunt.sv
module fcs_hunt #(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       take,
    input  logic       mode,
    input  logic [7:0] byte_i,
    output logic       found
);
    import fcs_pkg::*;

    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;
    logic          is_ff;
    logic          found_plain;
    logic          found_packed;

    assign is_ff        = (byte_i == FILL_BYTE);
    assign found_plain  = take && is_ff && (run_cnt == CW'(RUN_LEN - 1));
    assign found_packed = take && (run_cnt != '0) && is_sync_tail(byte_i);
    assign found        = mode ? found_packed : found_plain;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_cnt <= '0;
        end else if (take) begin
            if (!is_ff)
                run_cnt <= '0;
            else if (run_cnt != CW'(RUN_LEN - 1))
                run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fcs_shift.sv
module fcs_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] byte_i,
    output logic         active,
    output logic         cclk,
    output logic         din
);
    import fcs_pkg::*;

    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sr;
    logic [BW-1:0] bit_idx;
    bit_phase_e    phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sr      <= '0;
            bit_idx <= '0;
            phase   <= PH_LOW_IDLE;
        end else if (load) begin
            active  <= 1'b1;
            sr      <= byte_i;
            bit_idx <= '0;
            phase   <= PH_LOW_IDLE;
        end else if (active) begin
            case (phase)
                PH_LOW_IDLE:  phase <= PH_LOW_DATA;
                PH_LOW_DATA:  phase <= PH_HIGH_DATA;
                PH_HIGH_DATA: phase <= PH_HIGH_IDLE;
                default: begin
                    phase   <= PH_LOW_IDLE;
                    sr      <= sr << 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == BW'(W - 1))
                        active <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        cclk = 1'b1;
        din  = 1'b1;
        if (active) begin
            cclk = (phase == PH_HIGH_DATA) || (phase == PH_HIGH_IDLE);
            if ((phase == PH_LOW_DATA) || (phase == PH_HIGH_DATA))
                din = sr[W-1];
        end
    end

endmodule

// File: rtl/fcs_tmo.sv
module fcs_tmo #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick && (cnt != '1))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq #(
    parameter int RUN_LEN     = 4,
    parameter int FILL_CNT    = 8,
    parameter int INIT_LO_TMO = 3,
    parameter int INIT_HI_TMO = 3,
    parameter int DONE_TMO    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       cmp_mode,
    input  logic       ms_tick,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       prog_n,
    output logic       cclk,
    output logic       din,
    input  logic       init_n,
    input  logic       cfg_done,
    output logic       busy,
    output logic       ok,
    output logic [1:0] err
);
    import fcs_pkg::*;

    localparam int TMO_MAX = max3(INIT_LO_TMO, INIT_HI_TMO, DONE_TMO);
    localparam int TW      = $clog2(TMO_MAX + 1);
    localparam int PW      = $clog2(RUN_LEN + 1);
    localparam int FW      = $clog2(FILL_CNT + 1);

    seq_state_e    st, nxt;
    res_code_e     res_q, res_code;
    logic          ok_q;
    logic          mode_q;
    logic [PW-1:0] pend_ff;
    logic          hold_vld;
    logic [7:0]    hold_byte;
    logic          last_seen;
    logic [FW-1:0] fill_cnt;

    logic          hunt_take, hunt_found;
    logic          sh_load, sh_active, sh_cclk, sh_din;
    logic [7:0]    sh_byte;
    logic          tmr_clr, tmr_exp;
    logic [TW-1:0] tmr_limit;
    logic          ready_c, set_res, set_ok;
    logic          pend_dec, hold_clr, take_in, fill_inc;

    fcs_hunt #(.RUN_LEN(RUN_LEN)) u_hunt (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == ST_IDLE),
        .take   (hunt_take),
        .mode   (mode_q),
        .byte_i (in_data),
        .found  (hunt_found)
    );

    fcs_shift #(.W(8)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (sh_load),
        .byte_i (sh_byte),
        .active (sh_active),
        .cclk   (sh_cclk),
        .din    (sh_din)
    );

    fcs_tmo #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .tick    (ms_tick),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    always_comb begin
        nxt       = st;
        hunt_take = 1'b0;
        sh_load   = 1'b0;
        sh_byte   = FILL_BYTE;
        ready_c   = 1'b0;
        set_res   = 1'b0;
        set_ok    = 1'b0;
        res_code  = RES_NONE;
        tmr_limit = TW'(DONE_TMO);
        pend_dec  = 1'b0;
        hold_clr  = 1'b0;
        take_in   = 1'b0;
        fill_inc  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start)
                    nxt = ST_HUNT;
            end
            ST_HUNT: begin
                ready_c   = 1'b1;
                hunt_take = in_valid;
                if (hunt_found)
                    nxt = ST_PROG;
            end
            ST_PROG: begin
                tmr_limit = TW'(INIT_LO_TMO);
                if (!init_n) begin
                    nxt = ST_INIT_HI;
                end else if (tmr_exp) begin
                    set_res  = 1'b1;
                    res_code = RES_INIT_STUCK_HI;
                    nxt      = ST_IDLE;
                end
            end
            ST_INIT_HI: begin
                tmr_limit = TW'(INIT_HI_TMO);
                if (init_n) begin
                    nxt = ST_STREAM;
                end else if (tmr_exp) begin
                    set_res  = 1'b1;
                    res_code = RES_INIT_STUCK_LO;
                    nxt      = ST_IDLE;
                end
            end
            ST_STREAM: begin
                if (!sh_active) begin
                    if (pend_ff != '0) begin
                        sh_load  = 1'b1;
                        pend_dec = 1'b1;
                    end else if (hold_vld) begin
                        sh_load  = 1'b1;
                        sh_byte  = hold_byte;
                        hold_clr = 1'b1;
                    end else if (!last_seen) begin
                        ready_c = 1'b1;
                        if (in_valid) begin
                            sh_load = 1'b1;
                            sh_byte = in_data;
                            take_in = 1'b1;
                        end
                    end else if (fill_cnt != FW'(FILL_CNT)) begin
                        sh_load  = 1'b1;
                        fill_inc = 1'b1;
                    end else begin
                        nxt = ST_DONE_W;
                    end
                end
            end
            ST_DONE_W: begin
                tmr_limit = TW'(DONE_TMO);
                if (cfg_done) begin
                    set_ok = 1'b1;
                    nxt    = ST_IDLE;
                end else if (tmr_exp) begin
                    set_res  = 1'b1;
                    res_code = RES_NO_DONE;
                    nxt      = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        tmr_clr = (nxt != st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            res_q     <= RES_NONE;
            ok_q      <= 1'b0;
            mode_q    <= 1'b0;
            pend_ff   <= '0;
            hold_vld  <= 1'b0;
            hold_byte <= '0;
            last_seen <= 1'b0;
            fill_cnt  <= '0;
        end else begin
            st <= nxt;
            if ((st == ST_IDLE) && start) begin
                res_q     <= RES_NONE;
                ok_q      <= 1'b0;
                mode_q    <= cmp_mode;
                pend_ff   <= '0;
                hold_vld  <= 1'b0;
                last_seen <= 1'b0;
                fill_cnt  <= '0;
            end
            if (hunt_found) begin
                pend_ff   <= mode_q ? PW'(1) : PW'(RUN_LEN);
                hold_vld  <= mode_q;
                hold_byte <= in_data;
                last_seen <= in_last;
            end
            if (pend_dec)
                pend_ff <= pend_ff - 1'b1;
            if (hold_clr)
                hold_vld <= 1'b0;
            if (take_in)
                last_seen <= in_last;
            if (fill_inc)
                fill_cnt <= fill_cnt + 1'b1;
            if (set_res)
                res_q <= res_code;
            if (set_ok)
                ok_q <= 1'b1;
        end
    end

    assign in_ready = ready_c;
    assign prog_n   = (st != ST_PROG);
    assign cclk     = sh_cclk;
    assign din      = sh_din;
    assign busy     = (st != ST_IDLE);
    assign ok       = ok_q;
    assign err      = res_q;

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       in_ready,
    input logic       prog_n,
    input logic       cclk,
    input logic       din,
    input logic       cfg_done,
    input logic       busy,
    input logic       ok,
    input logic [1:0] err
);

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (prog_n && cclk && din && !in_ready));

    p_din_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(din));

    p_din_drop_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(din) |-> !cclk);

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_prog_lines_r6: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> (cclk && din && busy));

    p_ok_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> ($past(cfg_done) && !busy && err == 2'd0));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (!prog_n || !cclk) |-> !in_ready);

    p_hold_res_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err) && $stable(ok)));

endmodule

bind fpga_cfg_seq fcs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_ready (in_ready),
    .prog_n   (prog_n),
    .cclk     (cclk),
    .din      (din),
    .cfg_done (cfg_done),
    .busy     (busy),
    .ok       (ok),
    .err      (err)
);

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_CYC   = 40;
    localparam int RUN_LEN    = 4;
    localparam int FILL_CNT   = 8;
    localparam int TMO        = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cmp_mode = 1'b0;
    logic       ms_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       prog_n, cclk, din;
    logic       init_n = 1'b1;
    logic       cfg_done = 1'b0;
    logic       busy, ok;
    logic [1:0] err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] src_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];

    bit m_lo_en = 1, m_hi_en = 1, m_done_en = 1;
    int lo_ticks = 0;
    int stall_viol = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpga_cfg_seq #(
        .RUN_LEN(RUN_LEN), .FILL_CNT(FILL_CNT),
        .INIT_LO_TMO(TMO), .INIT_HI_TMO(TMO), .DONE_TMO(TMO)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .cmp_mode(cmp_mode),
        .ms_tick(ms_tick), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .prog_n(prog_n),
        .cclk(cclk), .din(din), .init_n(init_n), .cfg_done(cfg_done),
        .busy(busy), .ok(ok), .err(err)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // millisecond strobe; ticks seen by the design while prog_n is low are counted
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div == TICK_CYC - 1) ? 0 : tick_div + 1;
        ms_tick = (tick_div == 0) && !rst;
        if (ms_tick && !prog_n)
            lo_ticks++;
    end

    // configuration slave model
    int lo_cnt = 0, hi_cnt = 0;
    always @(negedge clk) begin
        if (!busy) begin
            init_n = 1'b1; lo_cnt = 0; hi_cnt = 0;
        end else if (!prog_n) begin
            lo_cnt++;
            if (m_lo_en && lo_cnt >= 5) init_n = 1'b0;
        end else if (!init_n) begin
            hi_cnt++;
            if (m_hi_en && hi_cnt >= 7) init_n = 1'b1;
        end
        cfg_done = m_done_en && busy && prog_n && (exp_q.size() > 0)
                   && (rx_q.size() >= exp_q.size());
    end

    // serial receiver: sample din on each observed rising cclk
    logic       prev_cclk = 1'b1;
    logic [7:0] acc = 8'h00;
    int         nbits = 0;
    always @(negedge clk) begin
        if (cclk && !prev_cclk) begin
            acc = {acc[6:0], din};
            nbits++;
            if (nbits == 8) begin
                rx_q.push_back(acc);
                nbits = 0;
            end
        end
        prev_cclk = cclk;
        if ((!prog_n || !cclk) && in_ready)
            stall_viol++;
    end

    function automatic int find_start(input bit mode);
        for (int i = 0; i < src_q.size(); i++) begin
            if (!mode) begin
                if (i + RUN_LEN <= src_q.size()) begin
                    bit all_ff = 1;
                    for (int k = 0; k < RUN_LEN; k++)
                        if (src_q[i + k] != 8'hFF) all_ff = 0;
                    if (all_ff) return i;
                end
            end else begin
                if (i + 1 < src_q.size() && src_q[i] == 8'hFF
                    && src_q[i + 1][7:4] == 4'h3)
                    return i;
            end
        end
        return -1;
    endfunction

    task automatic produce();
        int i = 0;
        while (i < src_q.size()) begin
            @(negedge clk);
            if ($urandom % 5 == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = src_q[i];
                in_last  = (i == src_q.size() - 1);
                #1;
                if (in_ready) i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_case(input bit mode, input bit lo_en, input bit hi_en,
                            input bit done_en, input int exp_err, input bit poke);
        int idx, mism, c;
        string rq;
        m_lo_en = lo_en; m_hi_en = hi_en; m_done_en = done_en;
        rx_q = {}; nbits = 0; stall_viol = 0;
        idx = find_start(mode);
        exp_q = {};
        for (int j = idx; j < src_q.size(); j++) exp_q.push_back(src_q[j]);
        for (int j = 0; j < FILL_CNT; j++) exp_q.push_back(8'hFF);
        @(negedge clk);
        cmp_mode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lo_ticks = 0;
        chk(busy == 1'b1 && in_ready == 1'b1, "R3", "busy/ready after start", busy, 1);
        chk(err == 2'd0 && ok == 1'b0, "R11", "result cleared by start", err, 0);
        fork
            produce();
            begin
                if (poke) begin
                    repeat (150) @(negedge clk);
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join_none
        c = 0;
        while (busy && c < 30000) begin
            @(negedge clk);
            c++;
        end
        disable fork;
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
        chk(c < 30000, "R9", "run finished", c, 0);
        chk(stall_viol == 0, "R10", "ready while stalled", stall_viol, 0);
        rq = mode ? "R5" : "R4";
        if (exp_err == 0) begin
            chk(ok == 1'b1 && err == 2'd0, "R9", "ok after done", ok, 1);
        end else begin
            chk(err == 2'(exp_err) && ok == 1'b0, (exp_err == 1) ? "R6" :
                (exp_err == 2) ? "R7" : "R9", "error code", err, exp_err);
        end
        if (exp_err == 1)
            chk(lo_ticks == TMO, "R6", "ticks before init-high timeout", lo_ticks, TMO);
        if (exp_err == 0 || exp_err == 3) begin
            chk(rx_q.size() == exp_q.size(), "R8", "serial byte count",
                rx_q.size(), exp_q.size());
            mism = 0;
            for (int j = 0; j < exp_q.size() && j < rx_q.size(); j++)
                if (rx_q[j] != exp_q[j]) mism++;
            chk(mism == 0, rq, "serial bytes (R2 msb-first)", mism, 0);
        end else begin
            chk(rx_q.size() == 0, "R6", "no data before handshake", rx_q.size(), 0);
        end
    endtask

    task automatic add_rand(input int n, input bit no_ff);
        for (int j = 0; j < n; j++) begin
            logic [7:0] r = 8'($urandom);
            if (no_ff && r == 8'hFF) r = 8'h5A;
            src_q.push_back(r);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(prog_n && cclk && din && !in_ready && !busy, "R1", "idle lines",
            {prog_n, cclk, din, in_ready, busy}, 5'b11100);
        chk(ok == 0 && err == 0, "R1", "reset result", err, 0);

        // plain preamble after header with a broken run
        src_q = '{8'h12, 8'hFF, 8'hFF, 8'hFF, 8'h00};
        add_rand(3, 1);
        repeat (RUN_LEN) src_q.push_back(8'hFF);
        add_rand(16, 0);
        run_case(0, 1, 1, 1, 0, 0);

        // packed preamble after lone 0xFF bytes
        src_q = '{8'hFF, 8'h12, 8'h55, 8'hFF, 8'hFF, 8'h35};
        add_rand(10, 0);
        run_case(1, 1, 1, 1, 0, 0);

        // long 0xFF run with a start pulse mid-run (ignored)
        src_q = '{8'h00};
        repeat (6) src_q.push_back(8'hFF);
        add_rand(12, 0);
        run_case(0, 1, 1, 1, 0, 1);

        // packed preamble whose second byte is the last byte
        src_q = '{8'h00, 8'hFF, 8'h3A};
        run_case(1, 1, 1, 1, 0, 0);

        // init never falls
        src_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01};
        run_case(0, 0, 1, 1, 1, 0);
        repeat (50) @(negedge clk);
        chk(err == 2'd1 && !busy, "R11", "error held while idle", err, 1);

        // init never rises again
        run_case(0, 1, 0, 1, 2, 0);

        // done never rises
        src_q = '{8'hFF, 8'h31, 8'hA5};
        run_case(1, 1, 1, 0, 3, 0);

        // random streams
        for (int it = 0; it < 4; it++) begin
            bit md = it[0];
            src_q = {};
            add_rand(1 + $urandom % 6, 1);
            if (md) begin
                src_q.push_back(8'hFF);
                src_q.push_back({4'h3, 4'($urandom)});
            end else begin
                repeat (RUN_LEN) src_q.push_back(8'hFF);
            end
            add_rand(4 + $urandom % 12, 0);
            run_case(md, 1, 1, 1, 0, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule